// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the 16-bit processor status word. The upper byte is the privileged system byte: it holds a trace enable, the supervisor flag and a 3-bit interrupt priority mask. The lower byte holds the five condition flags: extend, negative, zero, overflow and carry. Each cycle the execution unit presents an operation class and the flag outputs of its ALU. The block folds those flags into the status word according to the class.

The extend flag is kept apart from the carry flag. Only true arithmetic classes (add, subtract, negate, shift) copy the new carry into extend. Every other flag-setting class updates carry and leaves extend unchanged, so carry can serve as a general test flag while extend carries a multi-word arithmetic chain.

The block also applies the privilege rule to the system byte, which is writable only in supervisor mode. It accepts mode-change requests, such as exception entry or a return to user mode, and drives the select that picks the supervisor or the user stack pointer as the active stack pointer.

Top module: `status_word_reg`

## Requirements
- R1: After reset the status word reads 0x2700: supervisor bit 13 is 1, mask bits 10:8 are 7, trace bit 15 is 0 and flags X(4), N(3), Z(2), V(1), C(0) are all 0. `sp_sup_sel` is 1.
- R2: Bits 14, 12, 11 and 7:5 of the status word always read 0.
- R3: For op classes ADD=1, SUB=2, NEG=3 and SHIFT=4, N, Z, V and C take the ALU flag inputs on the next clock edge, and X takes the same value as the new C.
- R4: For op classes CMP=5, MOVE=6, LOGIC=7, MUL=8, DIV=9, TEST=10 and CLR=11, N, Z, V and C take the ALU flag inputs and X keeps its previous value.
- R5: Op class NONE=0 and the reserved classes 12 to 15 leave all five flags unchanged.
- R6: `ccr_wr` loads flags from `wr_data[4:0]` in either mode. It takes priority over any ALU update in the same cycle.
- R7: While S is 1, `sys_wr` loads T from `wr_data[15]`, S from `wr_data[13]` and the mask from `wr_data[10:8]`.
- R8: While S is 0, `sys_wr` has no effect on T, S or the mask.
- R9: `mode_req` with `mode_to_sup`=1 sets S, and with `mode_to_sup`=0 clears S, in either mode. T and the mask are left unchanged. A `mode_req` overrides a `sys_wr` in the same cycle.
- R10: `sp_sup_sel` equals the current S bit: 1 selects the supervisor stack pointer, 0 selects the user stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 4 | Operation class of the current ALU result |
| alu_n | input | 1 | ALU negative flag |
| alu_z | input | 1 | ALU zero flag |
| alu_v | input | 1 | ALU overflow flag |
| alu_c | input | 1 | ALU carry flag |
| ccr_wr | input | 1 | Explicit write of the condition flags |
| sys_wr | input | 1 | Explicit write of the system byte (privileged) |
| wr_data | input | 16 | Write data, in the same bit layout as the status word |
| mode_req | input | 1 | Mode change request |
| mode_to_sup | input | 1 | Target mode of the request: 1 is supervisor, 0 is user |
| status | output | 16 | Current status word |
| sp_sup_sel | output | 1 | Active stack pointer select (1 = supervisor) |

## Verification
The bench goes after the split between X and C. It sets X with an arithmetic carry and then runs each non-arithmetic class with the opposite carry. A design that tied X to C would clear X there.

The bench also attempts system-byte writes after dropping to user mode. A design that checked privilege against the incoming data rather than the current mode would let user code raise the mask or re-enter supervisor mode.

Same-cycle collisions are covered: a flag write against an ALU update, and a mode request against a system write. Getting either priority wrong shows up as the lower-priority value in the status word. The reserved op classes are also exercised, to catch a decoder that defaults to an update.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int SW_W   = 16;
    localparam int MASK_W = 3;
    localparam int OPC_W  = 4;

    localparam int BIT_T  = 15;
    localparam int BIT_S  = 13;
    localparam int BIT_I0 = 8;
    localparam int BIT_X  = 4;
    localparam int BIT_N  = 3;
    localparam int BIT_Z  = 2;
    localparam int BIT_V  = 1;
    localparam int BIT_C  = 0;

    localparam logic [MASK_W-1:0] RST_MASK = '1;

    typedef enum logic [OPC_W-1:0] {
        OPC_NONE  = 4'd0,
        OPC_ADD   = 4'd1,
        OPC_SUB   = 4'd2,
        OPC_NEG   = 4'd3,
        OPC_SHIFT = 4'd4,
        OPC_CMP   = 4'd5,
        OPC_MOVE  = 4'd6,
        OPC_LOGIC = 4'd7,
        OPC_MUL   = 4'd8,
        OPC_DIV   = 4'd9,
        OPC_TEST  = 4'd10,
        OPC_CLR   = 4'd11
    } opc_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic              t;
        logic              s;
        logic [MASK_W-1:0] mask;
    } sysb_t;

    typedef struct packed {
        sysb_t  sys;
        flags_t fl;
    } sr_state_t;

    function automatic logic [SW_W-1:0] pack_sr(sr_state_t st);
        logic [SW_W-1:0] w;
        w = '0;
        w[BIT_T] = st.sys.t;
        w[BIT_S] = st.sys.s;
        w[BIT_I0 +: MASK_W] = st.sys.mask;
        w[BIT_X] = st.fl.x;
        w[BIT_N] = st.fl.n;
        w[BIT_Z] = st.fl.z;
        w[BIT_V] = st.fl.v;
        w[BIT_C] = st.fl.c;
        return w;
    endfunction
endpackage

// File: rtl/sr_flag_unit.sv
module sr_flag_unit
    import sr_pkg::*;
(
    input  logic [OPC_W-1:0] op_class,
    input  logic             alu_n,
    input  logic             alu_z,
    input  logic             alu_v,
    input  logic             alu_c,
    input  logic             ccr_wr,
    input  logic [4:0]       wr_flags,
    input  flags_t           fl_q,
    output flags_t           fl_d
);
    typedef enum logic [1:0] {UPD_HOLD, UPD_KEEPX, UPD_ARITH} upd_e;
    upd_e upd;

    always_comb begin
        unique case (op_class)
            OPC_ADD, OPC_SUB, OPC_NEG, OPC_SHIFT:
                upd = UPD_ARITH;
            OPC_CMP, OPC_MOVE, OPC_LOGIC, OPC_MUL, OPC_DIV, OPC_TEST, OPC_CLR:
                upd = UPD_KEEPX;
            default:
                upd = UPD_HOLD;
        endcase
    end

    always_comb begin
        fl_d = fl_q;
        if (ccr_wr) begin
            fl_d.x = wr_flags[BIT_X];
            fl_d.n = wr_flags[BIT_N];
            fl_d.z = wr_flags[BIT_Z];
            fl_d.v = wr_flags[BIT_V];
            fl_d.c = wr_flags[BIT_C];
        end else if (upd != UPD_HOLD) begin
            fl_d.n = alu_n;
            fl_d.z = alu_z;
            fl_d.v = alu_v;
            fl_d.c = alu_c;
            if (upd == UPD_ARITH) fl_d.x = alu_c;
        end
    end
endmodule

// File: rtl/sr_sys_unit.sv
module sr_sys_unit
    import sr_pkg::*;
(
    input  sysb_t             sys_q,
    input  logic              sys_wr,
    input  logic              wr_t,
    input  logic              wr_s,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic              mode_req,
    input  logic              mode_to_sup,
    output sysb_t             sys_d,
    output logic              sp_sup_sel
);
    logic wr_granted;

    assign wr_granted = sys_wr && sys_q.s;

    always_comb begin
        sys_d = sys_q;
        if (mode_req) begin
            sys_d.s = mode_to_sup;
        end else if (wr_granted) begin
            sys_d.t    = wr_t;
            sys_d.s    = wr_s;
            sys_d.mask = wr_mask;
        end
    end

    assign sp_sup_sel = sys_q.s;
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
    import sr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPC_W-1:0]    op_class,
    input  logic                alu_n,
    input  logic                alu_z,
    input  logic                alu_v,
    input  logic                alu_c,
    input  logic                ccr_wr,
    input  logic                sys_wr,
    input  logic [SW_W-1:0]     wr_data,
    input  logic                mode_req,
    input  logic                mode_to_sup,
    output logic [SW_W-1:0]     status,
    output logic                sp_sup_sel
);
    localparam sr_state_t RST_STATE = '{
        sys: '{t: 1'b0, s: 1'b1, mask: RST_MASK},
        fl:  '0
    };

    sr_state_t state_q, state_d;
    flags_t    fl_d;
    sysb_t     sys_d;

    sr_flag_unit u_flag (
        .op_class (op_class),
        .alu_n    (alu_n),
        .alu_z    (alu_z),
        .alu_v    (alu_v),
        .alu_c    (alu_c),
        .ccr_wr   (ccr_wr),
        .wr_flags (wr_data[4:0]),
        .fl_q     (state_q.fl),
        .fl_d     (fl_d)
    );

    sr_sys_unit u_sys (
        .sys_q       (state_q.sys),
        .sys_wr      (sys_wr),
        .wr_t        (wr_data[BIT_T]),
        .wr_s        (wr_data[BIT_S]),
        .wr_mask     (wr_data[BIT_I0 +: MASK_W]),
        .mode_req    (mode_req),
        .mode_to_sup (mode_to_sup),
        .sys_d       (sys_d),
        .sp_sup_sel  (sp_sup_sel)
    );

    always_comb begin
        state_d     = state_q;
        state_d.fl  = fl_d;
        state_d.sys = sys_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RST_STATE;
        else        state_q <= state_d;
    end

    assign status = pack_sr(state_q);
endmodule

// File: rtl/sr_checker.sv
module sr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  op_class,
    input logic        alu_c,
    input logic        ccr_wr,
    input logic        sys_wr,
    input logic        mode_req,
    input logic        mode_to_sup,
    input logic [15:0] status,
    input logic        sp_sup_sel
);
    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[14] == 1'b0) && (status[12:11] == 2'b00) && (status[7:5] == 3'b000));

    // R3
    x_follows_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ccr_wr && op_class >= 4'd1 && op_class <= 4'd4)
        |=> (status[4] == status[0]) && (status[0] == $past(alu_c)));

    // R4
    x_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ccr_wr && op_class >= 4'd5 && op_class <= 4'd11) |=> $stable(status[4]));

    // R8
    user_sys_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[13] && sys_wr && !mode_req) |=> $stable(status[15:8]));

    // R9
    mode_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_req |=> (status[13] == $past(mode_to_sup)) && $stable(status[15]) && $stable(status[10:8]));

    // R10
    sp_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_sup_sel == status[13]);
endmodule

bind status_word_reg sr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_class    (op_class),
    .alu_c       (alu_c),
    .ccr_wr      (ccr_wr),
    .sys_wr      (sys_wr),
    .mode_req    (mode_req),
    .mode_to_sup (mode_to_sup),
    .status      (status),
    .sp_sup_sel  (sp_sup_sel)
);

// File: tb/tb_status_word_reg.sv
`timescale 1ns/1ps
module tb_status_word_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_class = '0;
    logic        alu_n = 0, alu_z = 0, alu_v = 0, alu_c = 0;
    logic        ccr_wr = 0, sys_wr = 0, mode_req = 0, mode_to_sup = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] status;
    logic        sp_sup_sel;

    int tests = 0;
    int fails = 0;
    logic [15:0] model;
    bit done = 0;

    always #5 clk = ~clk;

    status_word_reg dut (
        .clk(clk), .rst_n(rst_n), .op_class(op_class),
        .alu_n(alu_n), .alu_z(alu_z), .alu_v(alu_v), .alu_c(alu_c),
        .ccr_wr(ccr_wr), .sys_wr(sys_wr), .wr_data(wr_data),
        .mode_req(mode_req), .mode_to_sup(mode_to_sup),
        .status(status), .sp_sup_sel(sp_sup_sel)
    );

    function automatic logic [15:0] ref_next(logic [15:0] cur);
        logic [15:0] n;
        n = cur;
        if (ccr_wr) begin
            n[4:0] = wr_data[4:0];
        end else if (op_class >= 4'd1 && op_class <= 4'd4) begin
            n[3:0] = {alu_n, alu_z, alu_v, alu_c};
            n[4] = alu_c;
        end else if (op_class >= 4'd5 && op_class <= 4'd11) begin
            n[3:0] = {alu_n, alu_z, alu_v, alu_c};
        end
        if (mode_req) begin
            n[13] = mode_to_sup;
        end else if (sys_wr && cur[13]) begin
            n[15] = wr_data[15];
            n[13] = wr_data[13];
            n[10:8] = wr_data[10:8];
        end
        return n;
    endfunction

    function automatic string tag_of(logic [15:0] cur);
        if (mode_req) return "R9";
        if (sys_wr && !cur[13]) return "R8";
        if (sys_wr) return "R7";
        if (ccr_wr) return "R6";
        if (op_class >= 4'd1 && op_class <= 4'd4) return "R3";
        if (op_class >= 4'd5 && op_class <= 4'd11) return "R4";
        return "R5";
    endfunction

    task automatic check(string req, logic [15:0] exp);
        tests++;
        if (status !== exp) begin
            fails++;
            $display("FAIL %s status actual=%h expected=%h", req, status, exp);
        end
        tests++;
        if (sp_sup_sel !== exp[13]) begin
            fails++;
            $display("FAIL R10 sp_sup_sel actual=%b expected=%b (%s)", sp_sup_sel, exp[13], req);
        end
        tests++;
        if ((status & 16'h58E0) !== 16'h0) begin
            fails++;
            $display("FAIL R2 unused bits actual=%h expected=0000", status & 16'h58E0);
        end
    endtask

    task automatic step(logic [3:0] oc, logic [3:0] nzvc, logic cw, logic sw,
                        logic [15:0] d, logic mr, logic mts);
        string req;
        op_class = oc;
        {alu_n, alu_z, alu_v, alu_c} = nzvc;
        ccr_wr = cw; sys_wr = sw; wr_data = d; mode_req = mr; mode_to_sup = mts;
        req = tag_of(model);
        model = ref_next(model);
        @(posedge clk);
        @(negedge clk);
        check(req, model);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = 16'h2700;
        check("R1", 16'h2700);

        // R3: add with carry sets X
        step(4'd1, 4'b0001, 0, 0, 16'h0, 0, 0);
        // R4: move with carry clear keeps X=1
        step(4'd6, 4'b0100, 0, 0, 16'h0, 0, 0);
        // R4: every non-arith class holds X
        for (int k = 5; k <= 11; k++) step(4'(k), 4'b1010, 0, 0, 16'h0, 0, 0);
        // R5: none and reserved classes hold flags
        step(4'd0, 4'b1111, 0, 0, 16'h0, 0, 0);
        for (int k = 12; k <= 15; k++) step(4'(k), 4'b0101, 0, 0, 16'h0, 0, 0);
        // R6: flag write beats ALU update
        step(4'd1, 4'b1111, 1, 0, 16'h0012, 0, 0);
        // R7: supervisor write, mask 3, trace on, stay supervisor
        step(4'd0, 4'b0, 0, 1, 16'hA300, 0, 0);
        // R7: drop to user via system write
        step(4'd0, 4'b0, 0, 1, 16'h0500, 0, 0);
        // R8: user tries to regain supervisor and raise mask
        step(4'd0, 4'b0, 0, 1, 16'hA700, 0, 0);
        // R6: flag write allowed in user mode
        step(4'd7, 4'b0000, 1, 0, 16'h001F, 0, 0);
        // R9: mode request beats system write
        step(4'd0, 4'b0, 0, 1, 16'h0000, 1, 1);
        step(4'd0, 4'b0, 0, 1, 16'h2700, 1, 0);
        step(4'd0, 4'b0, 0, 0, 16'h0, 1, 1);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[3:0], r[7:4], (r[10:8] == 3'd0), (r[13:11] < 3'd2),
                 16'($urandom), (r[17:14] == 4'd0), r[18]);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule